// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave side of a serial memory that speaks SPI in clock modes 0 and 3. A fast system clock oversamples the serial pins. The block then splits each select window into three phases: an 8-bit command, an optional 16-bit byte address, and a data phase.

In the data phase the block does one of two things:
- It streams bytes out of a byte-wide storage array, or the status byte supplied by a separate write/protection unit.
- It hands each incoming data byte to that unit as a strobe.

When the select window closes, the block reports which command the frame carried. The write/protection unit then decides whether a write-enable latch changes or a programming cycle starts.

The block also handles the framing rules:
- Deselecting the block aborts the current sequence.
- An unknown command keeps the output silent until the next select.
- While the storage is busy programming, every command except the status read is refused.

A hold input pauses a transfer at a bit boundary without losing its place in the sequence.

Top module: `spi_mem_front`

## Requirements
- R1: Command bytes arrive most significant bit first and decode as follows: 0x06 write-enable (frame_op 1), 0x04 write-disable (frame_op 2), 0x05 status read (frame_op 3), 0x01 status write (frame_op 4), 0x03 array read (frame_op 5), 0x02 array write (frame_op 6). Every other value is invalid.
- R2: The input bit is taken on the rising serial-clock edge. The output bit changes only after a falling serial-clock edge. Read bytes leave most significant bit first.
- R3: While cs_n is high, so_oe is low and any partial sequence is discarded. A sequence begins only after a falling edge of cs_n. After reset so_oe, byte_stb and frame_end are low.
- R4: After an array-read command and its address, so carries the array bytes at successive addresses for as long as the clock runs. The address after the top address is 0.
- R5: During a status read, each output byte is 0xFF when wr_busy is high at the moment that byte starts. Otherwise it is status_in.
- R6: After an invalid command, so_oe stays low and no byte_stb or frame_end is produced until cs_n has risen and fallen again.
- R7: Taking hold_n low while sck is low pauses the transfer and drives so_oe low. Clock and data transitions during the pause have no effect. Taking hold_n high while sck is low resumes the transfer at the same bit.
- R8: The address phase is 16 bits, most significant bit first. Only the low ADDR_W bits select a byte, and the upper bits are ignored.
- R9: In an array-write frame, each completed data byte gives a one-cycle byte_stb with byte_dat and byte_addr, and byte_addr advances by one per byte. A status-write frame gives a byte_stb for its data byte.
- R10: When cs_n rises after a valid, accepted command, frame_end pulses for one cycle and frame_op carries that command's code.
- R11: While wr_busy is high when a command completes, any command other than status read is refused. That frame gives no so_oe, no byte_stb and no frame_end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; low means the pin is high impedance |
| mem_addr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data, valid one clk after mem_addr |
| wr_busy | input | 1 | Programming cycle in progress |
| status_in | input | 8 | Status byte from the write/protection unit |
| byte_stb | output | 1 | One-cycle strobe for a received data byte |
| byte_addr | output | ADDR_W | Address of the strobed byte |
| byte_dat | output | 8 | Value of the strobed byte |
| frame_end | output | 1 | One-cycle pulse when an accepted frame closes |
| frame_op | output | 3 | Command code of the closed frame |

## Verification
Every pin passes through two synchroniser flops and one edge register. The command logic registers one more stage after that. As a result, so and so_oe settle about four clk cycles after the serial-clock fall that moves them, and byte_stb and frame_end appear about four cycles after the rising sck or cs_n edge. The bench holds each serial-clock half-period for eight clk cycles and samples so and so_oe on the falling clk edge just before it raises sck, so each bit is read long after it is due and long before it may change. Strobes and frame pulses are logged by a monitor on falling clk edges. They are compared only after cs_n has been high for sixteen cycles, so every pulse from the frame is already counted.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_WRDI  = 8'h04;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_WRSR  = 8'h01;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;

    localparam int CMD_BITS  = 8;
    localparam int ADDR_BITS = 16;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WREN  = 3'd1,
        OP_WRDI  = 3'd2,
        OP_RDSR  = 3'd3,
        OP_WRSR  = 3'd4,
        OP_READ  = 3'd5,
        OP_WRITE = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDATA,
        ST_STAT,
        ST_WDATA,
        ST_DONE,
        ST_BAD
    } st_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_ev_t;

    function automatic op_e decode_op(input logic [7:0] b);
        case (b)
            CMD_WREN:  return OP_WREN;
            CMD_WRDI:  return OP_WRDI;
            CMD_RDSR:  return OP_RDSR;
            CMD_WRSR:  return OP_WRSR;
            CMD_READ:  return OP_READ;
            CMD_WRITE: return OP_WRITE;
            default:   return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
    parameter int N = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta, stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= RST_VAL[g];
                stab <= RST_VAL[g];
            end else begin
                meta <= din[g];
                stab <= meta;
            end
        end
        assign dout[g] = stab;
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_front_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           sck,
    input  pin_ev_t           cs,
    input  logic              si_lvl,
    input  logic              hold_lvl,
    input  logic              hold_fall,
    input  logic              wr_busy,
    input  logic              tx_load,
    output st_e               st,
    output logic              paused,
    output logic [ADDR_W-1:0] ptr,
    output logic              byte_stb,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        byte_dat,
    output logic              frame_end,
    output op_e               frame_op
);
    localparam int CNT_W = $clog2(ADDR_BITS);

    logic [ADDR_BITS-1:0] shreg;
    logic [ADDR_BITS-1:0] shin;
    logic [CNT_W-1:0]     bcnt;
    op_e                  op;
    op_e                  dec;

    assign shin = {shreg[ADDR_BITS-2:0], si_lvl};
    assign dec  = decode_op(shin[CMD_BITS-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op        <= OP_NONE;
            bcnt      <= '0;
            shreg     <= '0;
            ptr       <= '0;
            paused    <= 1'b0;
            byte_stb  <= 1'b0;
            byte_addr <= '0;
            byte_dat  <= '0;
            frame_end <= 1'b0;
            frame_op  <= OP_NONE;
        end else begin
            byte_stb  <= 1'b0;
            frame_end <= 1'b0;
            if (cs.fall) begin
                st     <= ST_OPC;
                op     <= OP_NONE;
                bcnt   <= '0;
                paused <= 1'b0;
            end else if (cs.lvl) begin
                if (cs.rise && (st inside {ST_ADDR, ST_RDATA, ST_STAT, ST_WDATA, ST_DONE})) begin
                    frame_end <= 1'b1;
                    frame_op  <= op;
                end
                st     <= ST_IDLE;
                paused <= 1'b0;
            end else begin
                if (!sck.lvl && hold_fall)
                    paused <= 1'b1;
                else if (!sck.lvl && hold_lvl)
                    paused <= 1'b0;

                if (sck.rise && !paused) begin
                    shreg <= shin;
                    case (st)
                        ST_OPC: begin
                            bcnt <= bcnt + 1'b1;
                            if (bcnt == CNT_W'(CMD_BITS - 1)) begin
                                bcnt <= '0;
                                op   <= dec;
                                if (dec == OP_NONE)
                                    st <= ST_BAD;
                                else if (wr_busy && dec != OP_RDSR)
                                    st <= ST_BAD;
                                else begin
                                    case (dec)
                                        OP_RDSR:           st <= ST_STAT;
                                        OP_WRSR:           st <= ST_WDATA;
                                        OP_READ, OP_WRITE: st <= ST_ADDR;
                                        default:           st <= ST_DONE;
                                    endcase
                                end
                            end
                        end
                        ST_ADDR: begin
                            bcnt <= bcnt + 1'b1;
                            if (bcnt == CNT_W'(ADDR_BITS - 1)) begin
                                bcnt <= '0;
                                ptr  <= shin[ADDR_W-1:0];
                                st   <= (op == OP_READ) ? ST_RDATA : ST_WDATA;
                            end
                        end
                        ST_WDATA: begin
                            bcnt <= bcnt + 1'b1;
                            if (bcnt == CNT_W'(CMD_BITS - 1)) begin
                                bcnt      <= '0;
                                byte_stb  <= 1'b1;
                                byte_dat  <= shin[7:0];
                                byte_addr <= ptr;
                                ptr       <= ptr + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end

                if (tx_load && st == ST_RDATA)
                    ptr <= ptr + 1'b1;
            end
        end
    end

    // R11: a refused command lands in the silent state
    p_busy_reject_r11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPC && sck.rise && !paused && !cs.lvl && !cs.fall &&
         bcnt == CNT_W'(CMD_BITS - 1) && wr_busy && dec != OP_RDSR) |=> st == ST_BAD);

    // R4: each byte sent during a read moves the pointer by one, wrapping at the top
    p_rd_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_load && st == ST_RDATA && !cs.lvl && !cs.fall) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    // R6: nothing is strobed out of a rejected frame
    p_bad_nostb_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BAD && !cs.lvl) |=> !byte_stb);

endmodule

// File: rtl/spi_so_drive.sv
module spi_so_drive
    import spi_front_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_ev_t    sck,
    input  logic       cs_sel,
    input  logic       cs_start,
    input  logic       paused,
    input  logic       stream,
    input  logic       stat_mode,
    input  logic       busy,
    input  logic [7:0] status_in,
    input  logic [7:0] mem_rdata,
    output logic       so,
    output logic       so_oe,
    output logic       tx_load
);
    logic [6:0] txsh;
    logic [2:0] txcnt;
    logic       live;
    logic [7:0] src;

    assign src = stat_mode ? (busy ? 8'hFF : status_in) : mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            txsh    <= '0;
            txcnt   <= '0;
            live    <= 1'b0;
            so      <= 1'b0;
            so_oe   <= 1'b0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (cs_start || !cs_sel) begin
                live  <= 1'b0;
                txcnt <= '0;
            end else if (!paused && sck.fall && stream) begin
                txcnt <= txcnt + 1'b1;
                if (txcnt == 3'd0) begin
                    so      <= src[7];
                    txsh    <= src[6:0];
                    tx_load <= 1'b1;
                    live    <= 1'b1;
                end else begin
                    so   <= txsh[6];
                    txsh <= {txsh[5:0], 1'b0};
                end
            end
            so_oe <= cs_sel && !paused && live && stream;
        end
    end

    // R3: deselect silences the pin
    p_tri_desel_r3: assert property (@(posedge clk) disable iff (rst)
        !cs_sel |=> !so_oe);

    // R7: a paused transfer does not drive the pin
    p_tri_pause_r7: assert property (@(posedge clk) disable iff (rst)
        paused |=> !so_oe);

    // R2: the data bit moves only in response to a falling serial clock
    p_so_fall_only_r2: assert property (@(posedge clk) disable iff (rst)
        !sck.fall |=> $stable(so));

    // R5: a status byte started while busy begins with a one
    p_busy_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_load && $past(stat_mode) && $past(busy)) |-> so);

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
    import spi_front_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              wr_busy,
    input  logic [7:0]        status_in,
    output logic              byte_stb,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        byte_dat,
    output logic              frame_end,
    output logic [2:0]        frame_op
);
    localparam int NCTL = 3;

    logic [NCTL-1:0] ctl_s, ctl_p;
    logic            si_s;
    pin_ev_t         sck_ev, cs_ev;
    logic            hold_fall;
    st_e             st;
    logic            paused;
    logic            tx_load;
    op_e             fop;

    spi_sync2 #(.N(NCTL), .RST_VAL(3'b110)) u_sync_ctl (
        .clk (clk),
        .rst (rst),
        .din ({hold_n, cs_n, sck}),
        .dout(ctl_s)
    );

    spi_sync2 #(.N(1), .RST_VAL(1'b0)) u_sync_si (
        .clk (clk),
        .rst (rst),
        .din (si),
        .dout(si_s)
    );

    always_ff @(posedge clk) begin
        if (rst) ctl_p <= 3'b110;
        else     ctl_p <= ctl_s;
    end

    assign sck_ev    = '{lvl: ctl_s[0], rise: ctl_s[0] & ~ctl_p[0], fall: ~ctl_s[0] & ctl_p[0]};
    assign cs_ev     = '{lvl: ctl_s[1], rise: ctl_s[1] & ~ctl_p[1], fall: ~ctl_s[1] & ctl_p[1]};
    assign hold_fall = ~ctl_s[2] & ctl_p[2];

    spi_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck_ev),
        .cs       (cs_ev),
        .si_lvl   (si_s),
        .hold_lvl (ctl_s[2]),
        .hold_fall(hold_fall),
        .wr_busy  (wr_busy),
        .tx_load  (tx_load),
        .st       (st),
        .paused   (paused),
        .ptr      (mem_addr),
        .byte_stb (byte_stb),
        .byte_addr(byte_addr),
        .byte_dat (byte_dat),
        .frame_end(frame_end),
        .frame_op (fop)
    );

    spi_so_drive u_so (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck_ev),
        .cs_sel   (~cs_ev.lvl),
        .cs_start (cs_ev.fall),
        .paused   (paused),
        .stream   (st == ST_RDATA || st == ST_STAT),
        .stat_mode(st == ST_STAT),
        .busy     (wr_busy),
        .status_in(status_in),
        .mem_rdata(mem_rdata),
        .so       (so),
        .so_oe    (so_oe),
        .tx_load  (tx_load)
    );

    assign frame_op = fop;

    // R6: an invalid or refused command keeps the pin undriven
    p_bad_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        st == ST_BAD |=> !so_oe);

    // R10: a frame report carries a real command code
    p_frame_code_r10: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> frame_op != 3'd0);

endmodule

// File: tb/sim_spi_mem_front.sv
module sim_spi_mem_front;
    localparam int AW = 12;
    localparam int HP = 8;
    localparam int NV = 4;
    localparam logic [15:0] RV_ADDR [NV] = '{16'h0010, 16'h0FFE, 16'hA123, 16'h07FF};
    localparam int          RV_LEN  [NV] = '{3, 4, 2, 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wr_busy = 1'b0;
    logic [7:0] status_in = 8'h0C;
    logic so, so_oe, byte_stb, frame_end;
    logic [AW-1:0] mem_addr, byte_addr;
    logic [7:0] mem_rdata, byte_dat;
    logic [2:0] frame_op;

    int n_chk = 0, n_fail = 0;
    int fe_cnt = 0, cap_n = 0;
    logic [2:0] fe_op = '0;
    logic [AW-1:0] cap_addr [16];
    logic [7:0]    cap_dat  [16];
    logic hold_oe_seen = 1'b0;

    function automatic logic [7:0] mem_val(input logic [AW-1:0] a);
        return a[7:0] + {a[11:8], 4'h5};
    endfunction

    assign mem_rdata = mem_val(mem_addr);

    spi_mem_front #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_busy(wr_busy), .status_in(status_in), .byte_stb(byte_stb),
        .byte_addr(byte_addr), .byte_dat(byte_dat), .frame_end(frame_end),
        .frame_op(frame_op)
    );

    always @(negedge clk) begin
        if (frame_end) begin
            fe_cnt = fe_cnt + 1;
            fe_op  = frame_op;
        end
        if (byte_stb && cap_n < 16) begin
            cap_addr[cap_n] = byte_addr;
            cap_dat[cap_n]  = byte_dat;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clkw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_hold();
        clkw(HP);
        hold_n = 1'b0;
        clkw(HP);
        hold_oe_seen = hold_oe_seen | so_oe;
        for (int k = 0; k < 3; k++) begin
            si = ~si;
            sck = 1'b1;
            clkw(HP);
            hold_oe_seen = hold_oe_seen | so_oe;
            sck = 1'b0;
            clkw(HP);
        end
        hold_n = 1'b1;
        clkw(HP);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_at,
                        output logic [7:0] rx, output logic oe_all, output logic oe_any);
        rx = '0; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) do_hold();
            si = tx[i];
            clkw(HP);
            rx[i]  = so;
            oe_all = oe_all & so_oe;
            oe_any = oe_any | so_oe;
            sck = 1'b1;
            clkw(HP);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r; logic a, y;
        xfer(b, -1, r, a, y);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        clkw(HP);
    endtask

    task automatic cs_hi();
        clkw(2);
        cs_n = 1'b1;
        clkw(2 * HP);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        logic oa, oy;
        int fe0, c0;

        clkw(5);
        rst = 1'b0;
        clkw(3);
        // R3: quiet after reset
        chk(!so_oe && !byte_stb && !frame_end, "R3 reset outputs", {so_oe, byte_stb, frame_end}, 0);

        // R2/R4/R8: table of read frames
        for (int v = 0; v < NV; v++) begin
            cs_lo();
            send(8'h03);
            send(RV_ADDR[v][15:8]);
            send(RV_ADDR[v][7:0]);
            for (int k = 0; k < RV_LEN[v]; k++) begin
                logic [AW-1:0] ea;
                ea = AW'(RV_ADDR[v][AW-1:0] + AW'(k));
                xfer(8'h00, -1, rx, oa, oy);
                chk(rx == mem_val(ea) && oa, "R2/R4/R8 read stream byte", {oa, rx}, {1'b1, mem_val(ea)});
            end
            cs_hi();
        end

        // R1/R10: enable and disable commands report on deselect
        fe0 = fe_cnt;
        cs_lo(); send(8'h06); cs_hi();
        chk(fe_cnt == fe0 + 1 && fe_op == 3'd1, "R1/R10 write-enable frame", {fe_cnt - fe0, fe_op}, {1, 3'd1});
        fe0 = fe_cnt;
        cs_lo(); send(8'h04); cs_hi();
        chk(fe_cnt == fe0 + 1 && fe_op == 3'd2, "R1/R10 write-disable frame", {fe_cnt - fe0, fe_op}, {1, 3'd2});

        // R5: status read idle and busy
        cs_lo(); send(8'h05); xfer(8'h00, -1, rx, oa, oy); cs_hi();
        chk(rx == 8'h0C && oa, "R5 status idle", rx, 8'h0C);
        wr_busy = 1'b1;
        cs_lo(); send(8'h05); xfer(8'h00, -1, rx, oa, oy); cs_hi();
        wr_busy = 1'b0;
        chk(rx == 8'hFF && oa, "R5 status busy", rx, 8'hFF);

        // R6: invalid command silences output until the next select
        fe0 = fe_cnt; c0 = cap_n;
        cs_lo(); send(8'hA5);
        xfer(8'h3C, -1, rx, oa, oy);
        chk(!oy, "R6 invalid no drive byte1", oy, 0);
        xfer(8'hC3, -1, rx, oa, oy);
        chk(!oy, "R6 invalid no drive byte2", oy, 0);
        cs_hi();
        chk(fe_cnt == fe0 && cap_n == c0, "R6 invalid no reports", fe_cnt - fe0 + cap_n - c0, 0);
        cs_lo(); send(8'h05); xfer(8'h00, -1, rx, oa, oy); cs_hi();
        chk(rx == 8'h0C && oa, "R6 recover after new select", rx, 8'h0C);

        // R8/R9/R10: array write
        c0 = cap_n; fe0 = fe_cnt;
        cs_lo(); send(8'h02); send(8'h12); send(8'h34); send(8'hAA); send(8'h55); cs_hi();
        chk(cap_n == c0 + 2, "R9 write strobe count", cap_n - c0, 2);
        chk(cap_addr[c0] == 12'h234 && cap_dat[c0] == 8'hAA, "R8/R9 first write byte", {cap_addr[c0], cap_dat[c0]}, {12'h234, 8'hAA});
        chk(cap_addr[c0+1] == 12'h235 && cap_dat[c0+1] == 8'h55, "R9 second write byte", {cap_addr[c0+1], cap_dat[c0+1]}, {12'h235, 8'h55});
        chk(fe_cnt == fe0 + 1 && fe_op == 3'd6, "R10 write frame", {fe_cnt - fe0, fe_op}, {1, 3'd6});

        // R7: hold during a write data byte, toggling clock and data while paused
        c0 = cap_n;
        cs_lo(); send(8'h02); send(8'h00); send(8'h40);
        xfer(8'hC3, 4, rx, oa, oy);
        cs_hi();
        chk(cap_n == c0 + 1 && cap_dat[c0] == 8'hC3 && cap_addr[c0] == 12'h040, "R7 held write byte intact", {cap_addr[c0], cap_dat[c0]}, {12'h040, 8'hC3});

        // R7: hold during a read byte resumes at the same bit
        hold_oe_seen = 1'b0;
        cs_lo(); send(8'h03); send(8'h00); send(8'h20);
        xfer(8'h00, 5, rx, oa, oy);
        chk(rx == mem_val(12'h020), "R7 held read byte", rx, mem_val(12'h020));
        chk(!hold_oe_seen, "R7 output off while held", hold_oe_seen, 0);
        xfer(8'h00, -1, rx, oa, oy);
        chk(rx == mem_val(12'h021) && oa, "R7 read continues after hold", rx, mem_val(12'h021));
        cs_hi();

        // R9/R10: status write
        c0 = cap_n; fe0 = fe_cnt;
        cs_lo(); send(8'h01); send(8'h8C); cs_hi();
        chk(cap_n == c0 + 1 && cap_dat[c0] == 8'h8C, "R9 status write byte", cap_dat[c0], 8'h8C);
        chk(fe_cnt == fe0 + 1 && fe_op == 3'd4, "R10 status write frame", {fe_cnt - fe0, fe_op}, {1, 3'd4});

        // R11: commands refused while busy
        wr_busy = 1'b1;
        c0 = cap_n; fe0 = fe_cnt;
        cs_lo(); send(8'h02); send(8'h00); send(8'h50); send(8'h77); cs_hi();
        chk(cap_n == c0 && fe_cnt == fe0, "R11 busy write refused", cap_n - c0 + fe_cnt - fe0, 0);
        cs_lo(); send(8'h03); send(8'h00); send(8'h10);
        xfer(8'h00, -1, rx, oa, oy);
        cs_hi();
        chk(!oy, "R11 busy read refused", oy, 0);
        wr_busy = 1'b0;

        // R3: abort mid-command, then a fresh select works
        cs_lo();
        for (int i = 0; i < 4; i++) begin
            si = 1'b0; clkw(HP); sck = 1'b1; clkw(HP); sck = 1'b0;
        end
        cs_hi();
        cs_lo(); send(8'h05); xfer(8'h00, -1, rx, oa, oy); cs_hi();
        chk(rx == 8'h0C && oa, "R3 restart after abort", rx, 8'h0C);

        // R3: deselect during a read stream turns the output off
        cs_lo(); send(8'h03); send(8'h00); send(8'h00);
        xfer(8'h00, -1, rx, oa, oy);
        chk(oa, "R3 driven while selected", oa, 1);
        cs_n = 1'b1;
        clkw(HP);
        chk(!so_oe, "R3 output off when deselected", so_oe, 0);
        clkw(HP);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule